// File: doc/BRIEF.md
# Auto-Incrementing Parallel Register Port

This block lets a host processor reach a bank of 64 eight-bit control registers through a narrow parallel bus. The bus has an active-low chip select, a read/write line, a two-bit address and one shared eight-bit bidirectional data lane. Address bit 0 picks the target of a transfer. When it is 0 the transfer goes to an internal six-bit location pointer. When it is 1 the transfer goes to the register that the pointer currently names. Address bit 1 has no effect.

A host normally loads the pointer once and then streams reads or writes. Each data transfer moves the pointer forward by one. The pointer stops at the last location and does not wrap. Every register is presented continuously to the rest of the chip on a flat output vector.

A mode input hands the register set to a separate serial port, which is not part of this block. While that input is set, this port is silent. Reset stops the access machinery and clears the pointer. It does not touch the register contents.

Top module: `hostreg_port`

## Requirements
- R1: A write with address bit 0 low loads the pointer from data bits 5:0. Bits 7:6 are discarded.
- R2: A read with address bit 0 low returns the pointer in bits 5:0, with bits 7:6 as zero.
- R3: A write with address bit 0 high stores the data byte in the register named by the pointer. That byte appears on `regs_o` bits [8*n+7:8*n] for register n after the transfer edge.
- R4: During a read strobe with address bit 0 high, the bus carries the register named by the pointer in the cycle from the strobe start up to its transfer edge.
- R5: Every data transfer (address bit 0 high, read or write) advances the pointer by one at its transfer edge. Pointer transfers do not advance it.
- R6: Data transfers at location 63 leave the pointer at 63.
- R7: A transfer happens only on the clock edge where chip select is low after being high on the previous edge. Holding chip select low for several cycles gives exactly one transfer.
- R8: The data bus is driven only while chip select is low, read/write is high (read), the serial mode input is low and reset is released. At all other times it is high-impedance.
- R9: An active-low reset returns the pointer to 0. Register contents are unchanged by reset.
- R10: Strobes that occur while reset is held have no effect on the pointer or the registers.
- R11: While the serial mode input is high, strobes on this port change neither the pointer nor the registers.
- R12: If chip select is already low when reset is released, no transfer happens until chip select has gone high and low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset and power-down |
| ser_mode_i | input | 1 | High hands the registers to the serial port and silences this port |
| cs_n_i | input | 1 | Active-low chip select strobe |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 2 | Bit 0: 0 = pointer, 1 = register data; bit 1 unused |
| bus_io | inout | 8 | Shared bidirectional data lane |
| regs_o | output | 512 | All registers, register n in bits [8n+7:8n] |

## Verification
A wrong pointer value shows up on the very next pointer read, and on the first data transfer after it, because that transfer lands on a neighbouring location of `regs_o`. A broken strobe detector shows up as a pointer that has jumped by more than one after a long strobe. A wrong saturation rule shows up as a write landing on register 0 instead of 63. Reset or serial-mode leakage shows up as a changed pointer or register on the transfer that follows the disturbance, and a stray bus driver corrupts the value the host itself places on the lane.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
    typedef enum logic {
        TGT_PTR  = 1'b0,
        TGT_DATA = 1'b1
    } tgt_e;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;
endpackage

// File: rtl/hrp_strobe.sv
module hrp_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    output logic access_o
);
    typedef struct packed {
        logic sel_prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.sel_prev = sel_i;
        access_o      = sel_i && !st_q.sel_prev;
    end

    // Reset value "was selected" forces a fresh falling strobe after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sel_prev: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/hrp_pointer.sv
module hrp_pointer
    import hostreg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access_i,
    input  tgt_e              tgt_i,
    input  dir_e              dir_i,
    input  logic [ADDR_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam logic [ADDR_W-1:0] PTR_MAX = {ADDR_W{1'b1}};

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (access_i) begin
            if (tgt_i == TGT_PTR) begin
                if (dir_i == DIR_WRITE) st_d.ptr = wdata_i;
            end else if (st_q.ptr != PTR_MAX) begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;
endmodule

// File: rtl/hrp_regbank.sv
module hrp_regbank #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 6,
    parameter int NUM_REGS = 2 ** ADDR_W
) (
    input  logic                       clk,
    input  logic                       we_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    output logic [DATA_W-1:0]          rdata_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (we_i) regs_d[addr_i] = wdata_i;
    end

    // No reset: contents must survive reset and power-down.
    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign rdata_o = regs_q[addr_i];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_flat
        assign regs_o[gi*DATA_W +: DATA_W] = regs_q[gi];
    end
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
    import hostreg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    localparam int NUM_REGS = 2 ** ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_mode_i,
    input  logic                       cs_n_i,
    input  logic                       rd_wr_i,
    input  logic [1:0]                 addr_i,
    inout  wire  [DATA_W-1:0]          bus_io,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    tgt_e              tgt;
    dir_e              dir;
    logic              sel;
    logic              access;
    logic              bus_oe;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] reg_rdata;
    logic [DATA_W-1:0] rd_val;
    logic              unused_addr_hi;

    assign tgt            = tgt_e'(addr_i[0]);
    assign dir            = dir_e'(rd_wr_i);
    assign unused_addr_hi = addr_i[1];
    assign sel            = !cs_n_i && !ser_mode_i;

    hrp_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (sel),
        .access_o (access)
    );

    hrp_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .access_i (access),
        .tgt_i    (tgt),
        .dir_i    (dir),
        .wdata_i  (bus_io[ADDR_W-1:0]),
        .ptr_o    (ptr)
    );

    hrp_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .we_i    (access && tgt == TGT_DATA && dir == DIR_WRITE),
        .addr_i  (ptr),
        .wdata_i (bus_io),
        .rdata_o (reg_rdata),
        .regs_o  (regs_o)
    );

    always_comb begin
        if (tgt == TGT_PTR) rd_val = {{(DATA_W-ADDR_W){1'b0}}, ptr};
        else                rd_val = reg_rdata;
    end

    assign bus_oe = rst_n && sel && (dir == DIR_READ);
    assign bus_io = bus_oe ? rd_val : {DATA_W{1'bz}};
endmodule

// File: rtl/hostreg_port_chk.sv
module hostreg_port_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_mode,
    input logic              cs_n,
    input logic              rd_wr,
    input logic              tgt_data,
    input logic              access,
    input logic              bus_oe,
    input logic [ADDR_W-1:0] wbits,
    input logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] PTR_MAX = {ADDR_W{1'b1}};

    p_ptr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        access && !tgt_data && !rd_wr |=> ptr == $past(wbits));

    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        access && tgt_data && ptr != PTR_MAX |=> ptr == $past(ptr) + 1'b1);

    p_ptr_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        access && tgt_data && ptr == PTR_MAX |=> ptr == PTR_MAX);

    p_single_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> !access);

    p_bus_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !rd_wr || ser_mode) |-> !bus_oe);

    p_reset_ptr_r9: assert property (@(posedge clk)
        $rose(rst_n) |-> ptr == '0);

    p_serial_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ser_mode |-> !access);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !access |=> $stable(ptr));
endmodule

bind hostreg_port hostreg_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_mode (ser_mode_i),
    .cs_n     (cs_n_i),
    .rd_wr    (rd_wr_i),
    .tgt_data (addr_i[0]),
    .access   (access),
    .bus_oe   (bus_oe),
    .wbits    (bus_io[ADDR_W-1:0]),
    .ptr      (ptr)
);

// File: tb/tb_hostreg_port.sv
module tb_hostreg_port;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_mode = 1'b0;
    logic         cs_n = 1'b1;
    logic         rd_wr = 1'b1;
    logic [1:0]   addr = 2'b00;
    logic         tb_oe = 1'b0;
    logic [7:0]   tb_val = 8'h00;
    wire  [7:0]   bus;
    logic [511:0] regs;
    int           n_checks = 0;
    int           n_errors = 0;
    logic [7:0]   rv;

    assign bus = tb_oe ? tb_val : 8'hzz;

    always #5 clk = ~clk;

    hostreg_port dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_mode_i (ser_mode),
        .cs_n_i     (cs_n),
        .rd_wr_i    (rd_wr),
        .addr_i     (addr),
        .bus_io     (bus),
        .regs_o     (regs)
    );

    function automatic logic [7:0] reg_at(int idx);
        return regs[idx*8 +: 8];
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One strobe; read value sampled before the transfer edge.
    task automatic strobe(input logic rd, input logic data_tgt, input logic [7:0] wv,
                          input int hold, output logic [7:0] got);
        @(negedge clk);
        cs_n = 1'b0; rd_wr = rd; addr = {1'b0, data_tgt};
        tb_oe = !rd; tb_val = wv;
        #2 got = bus;
        repeat (hold) @(negedge clk);
        cs_n = 1'b1; tb_oe = 1'b0; rd_wr = 1'b1;
    endtask

    task automatic set_ptr(logic [7:0] v);
        logic [7:0] d;
        strobe(1'b0, 1'b0, v, 1, d);
    endtask

    task automatic get_ptr(output logic [7:0] v);
        strobe(1'b1, 1'b0, 8'h00, 1, v);
    endtask

    task automatic wr_data(logic [7:0] v);
        logic [7:0] d;
        strobe(1'b0, 1'b1, v, 1, d);
    endtask

    task automatic rd_data(output logic [7:0] v);
        strobe(1'b1, 1'b1, 8'h00, 1, v);
    endtask

    task automatic t_reset_state;
        get_ptr(rv); chk("R9 pointer after reset", rv, 8'h00);
    endtask

    task automatic t_pointer;
        set_ptr(8'h25); get_ptr(rv); chk("R1/R2 pointer load 25", rv, 8'h25);
        set_ptr(8'hC7); get_ptr(rv); chk("R1 truncated load C7", rv, 8'h07);
        get_ptr(rv); chk("R2 pointer read no advance", rv, 8'h07);
    endtask

    task automatic t_stream;
        set_ptr(8'd10);
        wr_data(8'h3C); wr_data(8'hA1); wr_data(8'h7E);
        @(negedge clk);
        chk("R3 reg10", reg_at(10), 8'h3C);
        chk("R3 reg11", reg_at(11), 8'hA1);
        chk("R3 reg12", reg_at(12), 8'h7E);
        get_ptr(rv); chk("R5 pointer after 3 writes", rv, 8'd13);
        set_ptr(8'd10);
        rd_data(rv); chk("R4 read reg10", rv, 8'h3C);
        rd_data(rv); chk("R4 read reg11", rv, 8'hA1);
        rd_data(rv); chk("R4 read reg12", rv, 8'h7E);
        get_ptr(rv); chk("R5 pointer after 3 reads", rv, 8'd13);
    endtask

    task automatic t_saturate;
        set_ptr(8'd0); wr_data(8'h11);
        set_ptr(8'd62);
        wr_data(8'h62); wr_data(8'hB0); wr_data(8'hC3);
        @(negedge clk);
        chk("R6 reg62", reg_at(62), 8'h62);
        chk("R6 reg63 last write", reg_at(63), 8'hC3);
        chk("R6 reg0 untouched", reg_at(0), 8'h11);
        get_ptr(rv); chk("R6 pointer stuck at 63", rv, 8'd63);
        rd_data(rv); chk("R6 read at 63", rv, 8'hC3);
        get_ptr(rv); chk("R6 pointer after read", rv, 8'd63);
    endtask

    task automatic t_long_strobe;
        logic [7:0] d;
        set_ptr(8'd20);
        strobe(1'b0, 1'b1, 8'h5D, 5, d);
        @(negedge clk);
        chk("R7 reg20 written", reg_at(20), 8'h5D);
        get_ptr(rv); chk("R7 one advance per strobe", rv, 8'd21);
    endtask

    task automatic t_bus_quiet;
        set_ptr(8'd12);
        @(negedge clk);
        rd_wr = 1'b1; addr = 2'b01; cs_n = 1'b1; tb_oe = 1'b1; tb_val = 8'h00;
        #2 chk("R8 no drive with cs high", bus, 8'h00);
        addr = 2'b00;
        #1 chk("R8 no drive ptr target cs high", bus, 8'h00);
        @(negedge clk);
        tb_oe = 1'b0;
        get_ptr(rv); chk("R8 pointer unchanged", rv, 8'd12);
    endtask

    task automatic t_serial;
        logic [7:0] d;
        set_ptr(8'd12);
        ser_mode = 1'b1;
        strobe(1'b0, 1'b0, 8'h30, 1, d);
        strobe(1'b0, 1'b1, 8'hEE, 1, d);
        @(negedge clk);
        chk("R11 reg12 kept", reg_at(12), 8'h7E);
        ser_mode = 1'b0;
        get_ptr(rv); chk("R11 pointer kept", rv, 8'd12);
    endtask

    task automatic t_reset_keep;
        logic [7:0] d;
        set_ptr(8'd5); wr_data(8'h5A); set_ptr(8'd40);
        @(negedge clk); rst_n = 1'b0;
        strobe(1'b0, 1'b1, 8'hEE, 1, d);
        strobe(1'b0, 1'b0, 8'h22, 1, d);
        @(negedge clk);
        chk("R9 reg5 kept over reset", reg_at(5), 8'h5A);
        chk("R10 reg0 untouched in reset", reg_at(0), 8'h11);
        // chip select low across reset release
        cs_n = 1'b0; rd_wr = 1'b0; addr = 2'b00; tb_oe = 1'b1; tb_val = 8'h09;
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1; tb_oe = 1'b0; rd_wr = 1'b1;
        get_ptr(rv); chk("R12 no transfer on held select", rv, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_pointer();
        t_stream();
        t_saturate();
        t_long_strobe();
        t_bus_quiet();
        t_serial();
        t_reset_keep();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #500000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule